// File: doc/BRIEF.md
# Serial Command Port with Memory Dump

This block is a command port that a host drives over one data pin, a serial clock and a select line. While select is high, the port collects 16-bit control words one bit at a time. Each word holds a 4-bit command code in its upper bits and a 12-bit payload in its lower bits. Depending on the code, a word does one of three things: it writes one of six 12-bit setting registers, it loads a 12-bit control register, or it starts a dump. The two lowest bits of the control register choose one of four monitor sources for the analog side. All of these bits come up zero after reset.

On a dump, the data pin becomes an output for exactly 128 serial clocks. It streams a 128-bit store, arranged as eight 16-bit words, to the host. Words go out from the lowest address to the highest, and each word starts with its most significant bit. The pin then turns back into an input and the port takes the next command.

The store is modelled as a small memory with its own load port, so the contents can be placed ahead of time. The serial inputs are sampled on a fast system clock, and edges of the serial clock are found by comparing each sample with the one before. The pin splits into an input, an output and an output enable, so that a pad tristate can be placed above this block.

Top module: `serial_cmd_port`

## Requirements
- R1: Synchronous active-high reset clears all six setting registers, the control register and the monitor select, and drives the output enable low.
- R2: While select is high, one bit is taken from the data input at each rising serial-clock edge, most significant bit first. Every 16 bits form a word. Bits [15:12] are the command code and bits [11:0] are the payload.
- R3: Command codes 8 to D hex write the payload into setting register (code − 8). Register k occupies bits [12k+11:12k] of the register bus, and the other registers keep their values.
- R4: Command code F hex loads the payload into the control register. The monitor select equals control register bits [1:0].
- R5: Command codes 0 to 7 hex change no setting register and do not change the control register.
- R6: Command code E hex ignores its payload and starts a dump. The output enable rises at the next falling serial-clock edge. It stays high across exactly 128 rising edges and falls at the falling edge that follows the 128th.
- R7: During a dump the data output changes only at falling serial-clock edges and holds its value across each rising edge.
- R8: Bit n of the dump (n = 0 to 127, counted from the first rising edge) is bit 15 − (n mod 16) of store word n/16.
- R9: Data-input bits during a dump are not taken as command bits. The first 16 rising edges after the dump form the next command word.
- R10: Select low clears a partly received word and ends any dump, with the output enable low one system clock later. A full word sent after select returns is decoded correctly.
- R11: A pulse on the load port writes the 16-bit load data into the store word at the load address, and later dumps stream the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock, sampled on clk |
| sel | input | 1 | Port select, active high |
| dio_in | input | 1 | Serial data from the pin |
| dio_out | output | 1 | Serial data to the pin during a dump |
| dio_oe | output | 1 | High while the pin drives out |
| mem_ld_en | input | 1 | Store load strobe |
| mem_ld_addr | input | 3 | Store word address for a load |
| mem_ld_data | input | 16 | Store word value for a load |
| wr_regs | output | 72 | Six 12-bit setting registers, register 0 in the low bits |
| ctrl_reg | output | 12 | Control register |
| mon_sel | output | 2 | Monitor source select |

## Verification
The assertions rely on sclk, sel and dio_in being synchronous to clk. They also rely on each high or low phase of sclk lasting at least three system clocks, so that a decoded word has reached the registers and the dump logic before the next serial edge arrives. The bench changes every input on the falling edge of clk and holds each serial phase for four system clocks. It only lowers select after a full serial clock period. Under these conditions, a register can change only in the second system clock after a rising serial edge, and the output can change only right after a falling one.

// File: rtl/serial_cmd_pkg.sv
package serial_cmd_pkg;
  localparam int CMD_WR_FIRST = 8;
  localparam int CMD_DUMP     = 14;
  localparam int CMD_LOAD     = 15;
endpackage

// File: rtl/sclk_edges.sv
module sclk_edges (
  input  logic clk,
  input  logic rst,
  input  logic sclk,
  output logic rise,
  output logic fall
);
  logic sclk_q;

  always_ff @(posedge clk) begin
    if (rst) sclk_q <= 1'b0;
    else     sclk_q <= sclk;
  end

  assign rise = sclk & ~sclk_q;
  assign fall = ~sclk & sclk_q;
endmodule

// File: rtl/cmd_shifter.sv
module cmd_shifter #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              busy,
  input  logic              rise,
  input  logic              din,
  output logic              word_vld,
  output logic [WORD_W-1:0] word
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] sh;
  logic [WORD_W-1:0] nxt;

  assign nxt = {sh[WORD_W-2:0], din};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      sh       <= '0;
      word     <= '0;
      word_vld <= 1'b0;
    end else begin
      word_vld <= 1'b0;
      if (!sel) begin
        cnt <= '0;
      end else if (rise && !busy) begin
        sh <= nxt;
        if (cnt == LAST) begin
          cnt      <= '0;
          word     <= nxt;
          word_vld <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cmd_reg_file.sv
module cmd_reg_file
  import serial_cmd_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int CMD_W     = 4,
  parameter int N_WR_REGS = 6
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              word_vld,
  input  logic [WORD_W-1:0]                 word,
  output logic [N_WR_REGS*(WORD_W-CMD_W)-1:0] wr_regs,
  output logic [WORD_W-CMD_W-1:0]           ctrl_reg
);
  localparam int DATA_W = WORD_W - CMD_W;

  logic [CMD_W-1:0]  cmd;
  logic [DATA_W-1:0] data;

  assign cmd  = word[WORD_W-1 -: CMD_W];
  assign data = word[DATA_W-1:0];

  for (genvar i = 0; i < N_WR_REGS; i++) begin : g_wr
    always_ff @(posedge clk) begin
      if (rst)
        wr_regs[i*DATA_W +: DATA_W] <= '0;
      else if (word_vld && cmd == CMD_W'(CMD_WR_FIRST + i))
        wr_regs[i*DATA_W +: DATA_W] <= data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      ctrl_reg <= '0;
    else if (word_vld && cmd == CMD_W'(CMD_LOAD))
      ctrl_reg <= data;
  end
endmodule

// File: rtl/dump_streamer.sv
module dump_streamer #(
  parameter int MEM_WORDS = 8,
  parameter int WORD_W    = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         sel,
  input  logic                         rise,
  input  logic                         fall,
  input  logic                         start,
  input  logic                         ld_en,
  input  logic [$clog2(MEM_WORDS)-1:0] ld_addr,
  input  logic [WORD_W-1:0]            ld_data,
  output logic                         busy,
  output logic                         dout,
  output logic                         oe
);
  localparam int BITS  = MEM_WORDS * WORD_W;
  localparam int CNT_W = $clog2(BITS);
  localparam int BIT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BITS - 1);

  logic [WORD_W-1:0] store [MEM_WORDS];
  logic [CNT_W-1:0]  cnt;
  logic              active;

  always_ff @(posedge clk) begin
    if (ld_en) store[ld_addr] <= ld_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt    <= '0;
      oe     <= 1'b0;
      dout   <= 1'b0;
    end else if (!sel) begin
      active <= 1'b0;
      cnt    <= '0;
      oe     <= 1'b0;
    end else begin
      if (start) begin
        active <= 1'b1;
        cnt    <= '0;
      end else if (active && rise) begin
        if (cnt == LAST) begin
          active <= 1'b0;
          cnt    <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
      if (fall) begin
        oe <= active;
        if (active) dout <= store[cnt[CNT_W-1:BIT_W]][~cnt[BIT_W-1:0]];
      end
    end
  end

  assign busy = active;
endmodule

// File: rtl/serial_cmd_port.sv
module serial_cmd_port
  import serial_cmd_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int CMD_W     = 4,
  parameter int N_WR_REGS = 6,
  parameter int MEM_WORDS = 8,
  parameter int SEL_W     = 2
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                sclk,
  input  logic                                sel,
  input  logic                                dio_in,
  output logic                                dio_out,
  output logic                                dio_oe,
  input  logic                                mem_ld_en,
  input  logic [$clog2(MEM_WORDS)-1:0]        mem_ld_addr,
  input  logic [WORD_W-1:0]                   mem_ld_data,
  output logic [N_WR_REGS*(WORD_W-CMD_W)-1:0] wr_regs,
  output logic [WORD_W-CMD_W-1:0]             ctrl_reg,
  output logic [SEL_W-1:0]                    mon_sel
);
  localparam int DATA_W = WORD_W - CMD_W;

  logic              rise, fall, busy, word_vld, start;
  logic [WORD_W-1:0] word;

  sclk_edges u_edges (
    .clk (clk), .rst (rst), .sclk (sclk), .rise (rise), .fall (fall)
  );

  cmd_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk (clk), .rst (rst), .sel (sel), .busy (busy), .rise (rise),
    .din (dio_in), .word_vld (word_vld), .word (word)
  );

  cmd_reg_file #(.WORD_W(WORD_W), .CMD_W(CMD_W), .N_WR_REGS(N_WR_REGS)) u_regs (
    .clk (clk), .rst (rst), .word_vld (word_vld), .word (word),
    .wr_regs (wr_regs), .ctrl_reg (ctrl_reg)
  );

  assign start = word_vld && (word[WORD_W-1 -: CMD_W] == CMD_W'(CMD_DUMP));

  dump_streamer #(.MEM_WORDS(MEM_WORDS), .WORD_W(WORD_W)) u_dump (
    .clk (clk), .rst (rst), .sel (sel), .rise (rise), .fall (fall),
    .start (start), .ld_en (mem_ld_en), .ld_addr (mem_ld_addr),
    .ld_data (mem_ld_data), .busy (busy), .dout (dio_out), .oe (dio_oe)
  );

  assign mon_sel = ctrl_reg[SEL_W-1:0];
endmodule

// File: rtl/serial_cmd_port_chk.sv
module serial_cmd_port_chk #(
  parameter int REGS_W    = 72,
  parameter int DATA_W    = 12,
  parameter int SEL_W     = 2,
  parameter int DUMP_BITS = 128
) (
  input logic              clk,
  input logic              rst,
  input logic              sclk,
  input logic              sel,
  input logic              dio_out,
  input logic              dio_oe,
  input logic [REGS_W-1:0] wr_regs,
  input logic [DATA_W-1:0] ctrl_reg,
  input logic [SEL_W-1:0]  mon_sel
);
  localparam int RC_W = $clog2(DUMP_BITS) + 1;

  logic            sclk_d, rise_q;
  logic [RC_W-1:0] oe_rises;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d <= 1'b0;
      rise_q <= 1'b0;
    end else begin
      sclk_d <= sclk;
      rise_q <= sclk & ~sclk_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !dio_oe)   oe_rises <= '0;
    else if (sclk && !sclk_d) oe_rises <= oe_rises + 1'b1;
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (wr_regs == '0 && ctrl_reg == '0 && mon_sel == '0 && !dio_oe));

  // R5
  regs_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rise_q) |-> ($stable(wr_regs) && $stable(ctrl_reg)));

  // R6
  oe_rise_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dio_oe) |-> ($past(!sclk) && $past(sclk_d)));

  // R6
  oe_window_chk: assert property (@(posedge clk) disable iff (rst)
    oe_rises <= RC_W'(DUMP_BITS));

  // R7
  dout_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (dio_oe && $past(dio_oe) && !$stable(dio_out)) |-> ($past(!sclk) && $past(sclk_d)));

  // R10
  desel_release_chk: assert property (@(posedge clk) disable iff (rst)
    !sel |=> !dio_oe);
endmodule

bind serial_cmd_port serial_cmd_port_chk #(
  .REGS_W    (N_WR_REGS * DATA_W),
  .DATA_W    (DATA_W),
  .SEL_W     (SEL_W),
  .DUMP_BITS (MEM_WORDS * WORD_W)
) u_chk (
  .clk (clk), .rst (rst), .sclk (sclk), .sel (sel), .dio_out (dio_out),
  .dio_oe (dio_oe), .wr_regs (wr_regs), .ctrl_reg (ctrl_reg), .mon_sel (mon_sel)
);

// File: tb/serial_cmd_port_test.sv
module serial_cmd_port_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sclk = 1'b0, sel = 1'b0, dio_in = 1'b0;
  logic        mem_ld_en = 1'b0;
  logic [2:0]  mem_ld_addr = '0;
  logic [15:0] mem_ld_data = '0;
  logic        dio_out, dio_oe;
  logic [71:0] wr_regs;
  logic [11:0] ctrl_reg;
  logic [1:0]  mon_sel;

  int checks = 0, fails = 0;
  bit chk_ok = 1'b0, done = 1'b0;
  logic [11:0] exp_regs [6];
  logic [11:0] exp_ctrl = '0;
  logic        exp_oe = 1'b0, exp_dout = 1'b0;
  logic [15:0] mem_m [8];

  always #2 clk = ~clk;

  serial_cmd_port uut (
    .clk (clk), .rst (rst), .sclk (sclk), .sel (sel), .dio_in (dio_in),
    .dio_out (dio_out), .dio_oe (dio_oe), .mem_ld_en (mem_ld_en),
    .mem_ld_addr (mem_ld_addr), .mem_ld_data (mem_ld_data),
    .wr_regs (wr_regs), .ctrl_reg (ctrl_reg), .mon_sel (mon_sel)
  );

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [71:0] regs_flat();
    logic [71:0] f;
    for (int k = 0; k < 6; k++) f[k*12 +: 12] = exp_regs[k];
    return f;
  endfunction

  // Per-clock comparison against the model, during settled serial-low phases
  always @(negedge clk) begin
    if (chk_ok && !done) begin
      check(wr_regs == regs_flat(), "R3 register bus", wr_regs, regs_flat());
      check(ctrl_reg == exp_ctrl, "R4 control register", ctrl_reg, exp_ctrl);
      check(mon_sel == exp_ctrl[1:0], "R4 monitor select", mon_sel, exp_ctrl[1:0]);
      check(dio_oe == exp_oe, "R6 output enable", dio_oe, exp_oe);
      if (exp_oe) check(dio_out == exp_dout, "R8 dump bit", dio_out, exp_dout);
    end
  end

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_cycle(input logic b);
    sclk = 1'b0; dio_in = b; exp_oe = 1'b0;
    wait_clks(2); chk_ok = 1'b1; wait_clks(2); chk_ok = 1'b0;
    sclk = 1'b1; wait_clks(4);
  endtask

  task automatic send_word(input logic [15:0] w);
    for (int i = 15; i >= 0; i--) bit_cycle(w[i]);
    if (w[15:12] >= 4'h8 && w[15:12] <= 4'hD) exp_regs[w[15:12] - 4'h8] = w[11:0];
    else if (w[15:12] == 4'hF) exp_ctrl = w[11:0];
  endtask

  task automatic dump_read(input int nbits);
    for (int i = 0; i < nbits; i++) begin
      sclk = 1'b0; dio_in = i[0]; exp_oe = 1'b1;
      exp_dout = mem_m[i / 16][15 - (i % 16)];
      wait_clks(2); chk_ok = 1'b1; wait_clks(2); chk_ok = 1'b0;
      sclk = 1'b1; wait_clks(1);
      check(dio_out == exp_dout && dio_oe, "R8 bit at rising edge", dio_out, exp_dout);
      wait_clks(3);
      check(dio_out == exp_dout, "R7 held across high phase", dio_out, exp_dout);
    end
  endtask

  task automatic load_word(input int a, input logic [15:0] d);
    mem_ld_en = 1'b1; mem_ld_addr = 3'(a); mem_ld_data = d; mem_m[a] = d;
    wait_clks(1); mem_ld_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired act=running exp=finished");
    finish_run();
  end

  initial begin
    for (int k = 0; k < 6; k++) exp_regs[k] = '0;
    wait_clks(5);
    rst = 1'b0;
    wait_clks(1);
    // R1 reset state
    check(wr_regs == '0 && ctrl_reg == '0, "R1 regs after reset", {ctrl_reg, wr_regs}, 0);
    check(mon_sel == 2'd0 && !dio_oe, "R1 select/oe after reset", {mon_sel, dio_oe}, 0);

    // R11 preload store
    for (int a = 0; a < 8; a++) load_word(a, 16'(16'h8001 ^ (a * 16'h1357) ^ (a << 12)));
    sel = 1'b1;
    wait_clks(2);

    // R2 R3 writes to each register
    for (int k = 0; k < 6; k++) send_word({4'(8 + k), 12'(12'h1A3 + k * 12'h111)});
    wait_clks(1);
    check(wr_regs[24 +: 12] == 12'h3C5, "R3 register 2", wr_regs[24 +: 12], 12'h3C5);
    // R4 control load
    send_word(16'hF6A6);
    wait_clks(1);
    check(mon_sel == 2'd2, "R4 monitor select", mon_sel, 2);
    check(ctrl_reg == 12'h6A6, "R4 control value", ctrl_reg, 12'h6A6);
    // R5 low codes ignored
    send_word(16'h3FFF);
    send_word(16'h7000);
    send_word(16'h0555);
    wait_clks(1);
    check(wr_regs == regs_flat() && ctrl_reg == 12'h6A6, "R5 low codes ignored", wr_regs, regs_flat());

    // R6 dump start
    send_word(16'hE5A5);
    check(!dio_oe, "R6 oe low before first fall", dio_oe, 0);
    dump_read(128);
    check(dio_oe, "R6 oe held through 128th rise", dio_oe, 1);
    // R9 next word after dump decodes
    send_word(16'h9123);
    wait_clks(1);
    check(wr_regs[12 +: 12] == 12'h123, "R9 command after dump", wr_regs[12 +: 12], 12'h123);
    check(!dio_oe, "R6 oe released", dio_oe, 0);

    // R10 partial word then deselect
    for (int i = 0; i < 7; i++) bit_cycle(1'b1);
    sel = 1'b0; wait_clks(3); sel = 1'b1; wait_clks(2);
    send_word(16'hA777);
    wait_clks(1);
    check(wr_regs[24 +: 12] == 12'h777, "R10 word after deselect", wr_regs[24 +: 12], 12'h777);

    // R10 abort dump
    send_word(16'hE000);
    dump_read(20);
    sel = 1'b0; exp_oe = 1'b0;
    wait_clks(2);
    check(!dio_oe, "R10 deselect ends dump", dio_oe, 0);
    sel = 1'b1; wait_clks(2);
    send_word(16'hB0F0);
    wait_clks(1);
    check(wr_regs[36 +: 12] == 12'h0F0, "R10 command after abort", wr_regs[36 +: 12], 12'h0F0);

    // R11 reload and dump again
    load_word(3, 16'hC3A5);
    load_word(7, 16'h0001);
    send_word(16'hEFFF);
    dump_read(128);
    send_word(16'hF001);
    wait_clks(1);
    check(mon_sel == 2'd1, "R4 select after second dump", mon_sel, 1);
    wait_clks(4);
    finish_run();
  end
endmodule